// File: doc/BRIEF.md
# Priority Test-Bus Width Allocator

This block shares a fixed-width test bus among up to sixteen cores that are queued for test. Every clock cycle it looks at the cores that are waiting and do not yet hold bus width. It ranks them by the ratio of test patterns still to be applied to the core's present temperature, so a cool core with much work left comes first. It then walks the ranking once and grants each core whose requested width still fits in the free width. A core that does not fit is passed over, and the walk carries on with the next core.

A granted core keeps its width until it pulses its release line. The width that comes back that way is added to the free pool before the allocation pass of the same cycle. A core that asks for more width than the bus has can never be served. It is refused and marked with a sticky per-core error bit. A two-state controller records whether any width is free (open) or none is (full). In the full state the allocation pass is suppressed unless a release arrives in that cycle. The transition from open to full is taken when the width left after a pass is zero. The transition from full back to open is taken when width comes back and is not all granted again.

Top module: `testbus_width_alloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the grant vector and the error vector are all zero and the free width equals the bus limit BUS_LIMIT (24 by default).
- R2: A core is a candidate only if its waiting bit is high, it holds no width, and its request is at most BUS_LIMIT. Grants decided from the inputs of one clock edge appear on the grant vector for the single cycle that follows that edge.
- R3: Candidates are served in decreasing order of remaining/temperature, compared as remaining_a × temp_b against remaining_b × temp_a. On equal products the lower core index is served first.
- R4: The walk continues past a candidate whose request exceeds the width still free. Lower-ranked candidates that fit are still granted in the same pass.
- R5: The free-width output always equals BUS_LIMIT minus the sum of the widths held by cores. It never exceeds BUS_LIMIT, and nothing is granted while it is zero, except after a release in the same cycle.
- R6: A core that holds width is not granted again, whatever its waiting bit, until it releases.
- R7: A release from a holding core returns its granted width to the pool before that cycle's pass, so the width can be granted in the same cycle. A release from a core that holds nothing has no effect.
- R8: A waiting core whose request is above BUS_LIMIT is never granted. Its error bit is set in the next cycle and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_i | input | N_CORES | Per-core waiting-for-bus flag |
| req_i | input | N_CORES*REQ_W | Per-core requested width, core k in bits [k*REQ_W +: REQ_W] |
| rem_i | input | N_CORES*CNT_W | Per-core remaining pattern count |
| temp_i | input | N_CORES*TEMP_W | Per-core temperature reading |
| rel_i | input | N_CORES | Per-core release of held width |
| grant_o | output | N_CORES | One bit per core, high for one cycle when that core is granted |
| free_o | output | $clog2(BUS_LIMIT+1) | Width not currently held |
| err_o | output | N_CORES | Sticky oversize-request flag per core |

## Verification
Directed patterns separate the individual rules. One pattern has four candidates with distinct ratios, so the ranking alone decides which two fit. A pair with equal ratios exposes the tie rule. A wide top-ranked request followed by a too-wide second one and a narrow third shows whether the walk skips or stops. Releases paired with new waiters in the same cycle show whether returned width is usable at once. Releases from idle cores and oversize requests check the cases that must leave the state untouched or set the error bit. Several hundred cycles of seeded random waits, widths, counts, temperatures and releases then compare every output against a bench model of the greedy walk.

// File: rtl/twa_pkg.sv
package twa_pkg;

    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_FULL = 1'b1
    } twa_state_e;

endpackage

// File: rtl/twa_release.sv
module twa_release #(
    parameter int N_CORES = 8,
    parameter int REQ_W   = 5,
    parameter int FREE_W  = 5
) (
    input  logic [N_CORES-1:0]       rel,
    input  logic [N_CORES-1:0]       hold,
    input  logic [N_CORES*REQ_W-1:0] held_w,
    input  logic [FREE_W-1:0]        free_q,
    output logic [FREE_W-1:0]        free_pre,
    output logic [N_CORES-1:0]       hold_left,
    output logic                     rel_hit
);

    localparam int SUM_W = FREE_W + REQ_W + $clog2(N_CORES) + 1;

    logic [N_CORES-1:0] returning;
    logic [SUM_W-1:0]   acc;

    assign returning = rel & hold;
    assign hold_left = hold & ~returning;
    assign rel_hit   = |returning;

    always_comb begin
        acc = SUM_W'(free_q);
        for (int i = 0; i < N_CORES; i++) begin
            if (returning[i]) begin
                acc = acc + SUM_W'(held_w[i*REQ_W +: REQ_W]);
            end
        end
        free_pre = FREE_W'(acc);
    end

endmodule

// File: rtl/twa_rank.sv
module twa_rank #(
    parameter int N_CORES = 8,
    parameter int CNT_W   = 10,
    parameter int TEMP_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_CORES-1:0]        cand,
    input  logic [N_CORES*CNT_W-1:0]  rem_all,
    input  logic [N_CORES*TEMP_W-1:0] temp_all,
    output logic [N_CORES*IDX_W-1:0]  rank
);

    localparam int PROD_W = CNT_W + TEMP_W;

    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_rank
        logic [IDX_W-1:0]  ahead;
        logic [PROD_W-1:0] p_other;
        logic [PROD_W-1:0] p_self;

        always_comb begin
            ahead   = '0;
            p_other = '0;
            p_self  = '0;
            for (int j = 0; j < N_CORES; j++) begin
                if (j != gi && cand[j]) begin
                    p_other = PROD_W'(rem_all[j*CNT_W +: CNT_W]) *
                              PROD_W'(temp_all[gi*TEMP_W +: TEMP_W]);
                    p_self  = PROD_W'(rem_all[gi*CNT_W +: CNT_W]) *
                              PROD_W'(temp_all[j*TEMP_W +: TEMP_W]);
                    if (p_other > p_self || (p_other == p_self && j < gi)) begin
                        ahead = ahead + IDX_W'(1);
                    end
                end
            end
        end

        assign rank[gi*IDX_W +: IDX_W] = ahead;
    end

endmodule

// File: rtl/twa_walk.sv
module twa_walk #(
    parameter int N_CORES = 8,
    parameter int REQ_W   = 5,
    parameter int FREE_W  = 5,
    parameter int IDX_W   = 3
) (
    input  logic                     en,
    input  logic [N_CORES-1:0]       cand,
    input  logic [N_CORES*IDX_W-1:0] rank,
    input  logic [N_CORES*REQ_W-1:0] req,
    input  logic [FREE_W-1:0]        free_in,
    output logic [N_CORES-1:0]       grant,
    output logic [FREE_W-1:0]        free_out
);

    logic [FREE_W-1:0]  level;
    logic [N_CORES-1:0] sel;
    logic [REQ_W-1:0]   w;

    always_comb begin
        level = free_in;
        grant = '0;
        sel   = '0;
        w     = '0;
        for (int p = 0; p < N_CORES; p++) begin
            sel = '0;
            w   = '0;
            for (int i = 0; i < N_CORES; i++) begin
                if (cand[i] && rank[i*IDX_W +: IDX_W] == IDX_W'(p)) begin
                    sel[i] = 1'b1;
                    w      = w | req[i*REQ_W +: REQ_W];
                end
            end
            if (en && (sel != '0) && (level != '0) && (int'(w) <= int'(level))) begin
                grant = grant | sel;
                level = level - FREE_W'(w);
            end
        end
        free_out = level;
    end

endmodule

// File: rtl/testbus_width_alloc.sv
module testbus_width_alloc
    import twa_pkg::*;
#(
    parameter int N_CORES   = 8,
    parameter int REQ_W     = 5,
    parameter int CNT_W     = 10,
    parameter int TEMP_W    = 8,
    parameter int BUS_LIMIT = 24,
    localparam int FREE_W   = $clog2(BUS_LIMIT + 1),
    localparam int IDX_W    = $clog2(N_CORES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES-1:0]          wait_i,
    input  logic [N_CORES*REQ_W-1:0]    req_i,
    input  logic [N_CORES*CNT_W-1:0]    rem_i,
    input  logic [N_CORES*TEMP_W-1:0]   temp_i,
    input  logic [N_CORES-1:0]          rel_i,
    output logic [N_CORES-1:0]          grant_o,
    output logic [FREE_W-1:0]           free_o,
    output logic [N_CORES-1:0]          err_o
);

    twa_state_e state_q, state_d;

    logic [FREE_W-1:0]        free_q;
    logic [N_CORES-1:0]       hold_q;
    logic [N_CORES*REQ_W-1:0] held_w_q;
    logic [N_CORES-1:0]       grant_q;
    logic [N_CORES-1:0]       err_q;

    logic [FREE_W-1:0]        free_pre;
    logic [FREE_W-1:0]        free_post;
    logic [N_CORES-1:0]       hold_left;
    logic                     rel_hit;
    logic [N_CORES-1:0]       oversize;
    logic [N_CORES-1:0]       cand;
    logic [N_CORES*IDX_W-1:0] rank;
    logic [N_CORES-1:0]       grant_nx;
    logic                     pass_en;

    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_size
        assign oversize[gi] = int'(req_i[gi*REQ_W +: REQ_W]) > BUS_LIMIT;
    end

    twa_release #(
        .N_CORES (N_CORES),
        .REQ_W   (REQ_W),
        .FREE_W  (FREE_W)
    ) u_release (
        .rel       (rel_i),
        .hold      (hold_q),
        .held_w    (held_w_q),
        .free_q    (free_q),
        .free_pre  (free_pre),
        .hold_left (hold_left),
        .rel_hit   (rel_hit)
    );

    assign cand    = wait_i & ~hold_left & ~oversize;
    assign pass_en = (state_q == ST_OPEN) || rel_hit;

    twa_rank #(
        .N_CORES (N_CORES),
        .CNT_W   (CNT_W),
        .TEMP_W  (TEMP_W),
        .IDX_W   (IDX_W)
    ) u_rank (
        .cand     (cand),
        .rem_all  (rem_i),
        .temp_all (temp_i),
        .rank     (rank)
    );

    twa_walk #(
        .N_CORES (N_CORES),
        .REQ_W   (REQ_W),
        .FREE_W  (FREE_W),
        .IDX_W   (IDX_W)
    ) u_walk (
        .en       (pass_en),
        .cand     (cand),
        .rank     (rank),
        .req      (req_i),
        .free_in  (free_pre),
        .grant    (grant_nx),
        .free_out (free_post)
    );

    // Next-state decision: full when nothing is left after this cycle's pass.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (free_post == '0) state_d = ST_FULL;
            ST_FULL: if (free_post != '0) state_d = ST_OPEN;
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Pool, ledger and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q   <= FREE_W'(BUS_LIMIT);
            hold_q   <= '0;
            held_w_q <= '0;
            grant_q  <= '0;
            err_q    <= '0;
        end else begin
            free_q  <= free_post;
            hold_q  <= hold_left | grant_nx;
            grant_q <= grant_nx;
            err_q   <= err_q | (wait_i & oversize);
            for (int i = 0; i < N_CORES; i++) begin
                if (grant_nx[i]) begin
                    held_w_q[i*REQ_W +: REQ_W] <= req_i[i*REQ_W +: REQ_W];
                end
            end
        end
    end

    assign grant_o = grant_q;
    assign free_o  = free_q;
    assign err_o   = err_q;

endmodule

// File: rtl/twa_checker.sv
module twa_checker #(
    parameter int N_CORES   = 8,
    parameter int REQ_W     = 5,
    parameter int BUS_LIMIT = 24,
    parameter int FREE_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_CORES-1:0]       wait_i,
    input logic [N_CORES*REQ_W-1:0] req_i,
    input logic [N_CORES-1:0]       rel_i,
    input logic [N_CORES-1:0]       grant_o,
    input logic [FREE_W-1:0]        free_o,
    input logic [N_CORES-1:0]       err_o
);

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_o) <= BUS_LIMIT); // R5

    AST_FREE_DROP_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o < $past(free_o)) |-> (grant_o != '0)); // R5

    AST_GRANT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~$past(wait_i)) == '0); // R2

    AST_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(free_o) == '0 && $past(rel_i) == '0) |-> (grant_o == '0)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_o) & ~err_o) == '0); // R8

    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_core
        AST_NO_OVERSIZE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (int'($past(req_i[gi*REQ_W +: REQ_W])) > BUS_LIMIT) |-> !grant_o[gi]); // R8
    end

endmodule

bind testbus_width_alloc twa_checker #(
    .N_CORES   (N_CORES),
    .REQ_W     (REQ_W),
    .BUS_LIMIT (BUS_LIMIT),
    .FREE_W    (FREE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wait_i  (wait_i),
    .req_i   (req_i),
    .rel_i   (rel_i),
    .grant_o (grant_o),
    .free_o  (free_o),
    .err_o   (err_o)
);

// File: tb/sim_testbus_width_alloc.sv
module sim_testbus_width_alloc;

    localparam int N  = 8;
    localparam int RW = 5;
    localparam int CW = 10;
    localparam int TW = 8;
    localparam int BL = 24;
    localparam int FW = $clog2(BL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    wait_v, rel_v;
    logic [N*RW-1:0] req_v;
    logic [N*CW-1:0] rem_v;
    logic [N*TW-1:0] temp_v;
    logic [N-1:0]    grant_o, err_o;
    logic [FW-1:0]   free_o;

    testbus_width_alloc #(
        .N_CORES(N), .REQ_W(RW), .CNT_W(CW), .TEMP_W(TW), .BUS_LIMIT(BL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wait_i(wait_v), .req_i(req_v),
        .rem_i(rem_v), .temp_i(temp_v), .rel_i(rel_v),
        .grant_o(grant_o), .free_o(free_o), .err_o(err_o)
    );

    int wt[N], rq[N], rm[N], tp[N], rl[N];
    int m_hold[N], m_w[N], m_err[N];
    int m_free;
    int n_run, n_fail;

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            wait_v[i]            = (wt[i] != 0);
            rel_v[i]             = (rl[i] != 0);
            req_v[i*RW +: RW]    = RW'(rq[i]);
            rem_v[i*CW +: CW]    = CW'(rm[i]);
            temp_v[i*TW +: TW]   = TW'(tp[i]);
        end
    endtask

    task automatic clear_in();
        for (int i = 0; i < N; i++) begin
            wt[i] = 0; rl[i] = 0; rq[i] = 1; rm[i] = 1; tp[i] = 1;
        end
    endtask

    // One cycle: drive, predict from the requirements, clock, compare.
    task automatic step(input string tag);
        int free;
        int hold_t[N];
        int cand[N];
        int picked[N];
        int best;
        logic [N-1:0] eg;
        logic [N-1:0] ee;
        drive();
        free = m_free;
        eg = '0;
        ee = '0;
        for (int i = 0; i < N; i++) begin
            hold_t[i] = m_hold[i];
            picked[i] = 0;
            if (rl[i] != 0 && m_hold[i] != 0) begin
                free += m_w[i];
                hold_t[i] = 0;
            end
        end
        for (int i = 0; i < N; i++) begin
            cand[i] = (wt[i] != 0 && hold_t[i] == 0 && rq[i] <= BL) ? 1 : 0;
            ee[i]   = (m_err[i] != 0) || (wt[i] != 0 && rq[i] > BL);
        end
        for (int k = 0; k < N; k++) begin
            best = -1;
            for (int i = 0; i < N; i++) begin
                if (cand[i] != 0 && picked[i] == 0) begin
                    if (best < 0) best = i;
                    else if (longint'(rm[i]) * tp[best] > longint'(rm[best]) * tp[i]) best = i;
                end
            end
            if (best >= 0) begin
                picked[best] = 1;
                if (free > 0 && rq[best] <= free) begin
                    eg[best] = 1'b1;
                    free -= rq[best];
                end
            end
        end
        @(posedge clk);
        #1;
        n_run++;
        if (grant_o !== eg || free_o !== FW'(free) || err_o !== ee) begin
            n_fail++;
            $display("FAIL %s: grant=%b free=%0d err=%b expected grant=%b free=%0d err=%b",
                     tag, grant_o, free_o, err_o, eg, free, ee);
        end
        m_free = free;
        for (int i = 0; i < N; i++) begin
            m_hold[i] = (hold_t[i] != 0 || eg[i]) ? 1 : 0;
            if (eg[i]) m_w[i] = rq[i];
            m_err[i] = ee[i] ? 1 : 0;
        end
        @(negedge clk);
    endtask

    task automatic release_all(input string tag);
        clear_in();
        for (int i = 0; i < N; i++) rl[i] = 1;
        step(tag);
        clear_in();
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        n_run = 0;
        n_fail = 0;
        m_free = BL;
        for (int i = 0; i < N; i++) begin
            m_hold[i] = 0; m_w[i] = 0; m_err[i] = 0;
        end
        clear_in();
        drive();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0;
        n_run++;
        if (grant_o !== '0 || free_o !== FW'(BL) || err_o !== '0) begin
            n_fail++;
            $display("FAIL R1: grant=%b free=%0d err=%b expected grant=0 free=%0d err=0",
                     grant_o, free_o, err_o, BL);
        end
        step("R1");

        // R3: four distinct ratios, only two of width 10 fit in 24.
        clear_in();
        wt[0] = 1; rq[0] = 10; rm[0] = 100; tp[0] = 80;
        wt[1] = 1; rq[1] = 10; rm[1] = 300; tp[1] = 60;
        wt[2] = 1; rq[2] = 10; rm[2] = 50;  tp[2] = 90;
        wt[3] = 1; rq[3] = 10; rm[3] = 400; tp[3] = 50;
        step("R3");
        release_all("R7");

        // R3 tie: equal products, lower index first; then R6 hold.
        wt[2] = 1; rq[2] = 14; rm[2] = 200; tp[2] = 100;
        wt[5] = 1; rq[5] = 14; rm[5] = 100; tp[5] = 50;
        step("R3");
        step("R6");
        wt[2] = 0; rl[2] = 1;
        step("R7");
        release_all("R7");

        // R4: greedy skip of a too-wide second candidate.
        wt[0] = 1; rq[0] = 20; rm[0] = 500; tp[0] = 10;
        wt[1] = 1; rq[1] = 10; rm[1] = 400; tp[1] = 10;
        wt[2] = 1; rq[2] = 4;  rm[2] = 300; tp[2] = 10;
        step("R4");
        clear_in();
        wt[3] = 1; rq[3] = 1; rm[3] = 900; tp[3] = 5;
        step("R5");
        rl[3] = 1;
        step("R7");
        rl[3] = 0; rl[0] = 1; wt[1] = 1; rq[1] = 10; rm[1] = 400; tp[1] = 10;
        step("R7");
        release_all("R7");

        // R8: oversize request, then sticky flag.
        wt[4] = 1; rq[4] = 30; rm[4] = 999; tp[4] = 1;
        step("R8");
        wt[4] = 0;
        step("R8");

        // Random traffic.
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < N; i++) begin
                wt[i] = ($urandom_range(0, 2) != 0) ? 1 : 0;
                rq[i] = ($urandom_range(0, 15) == 0) ? int'($urandom_range(25, 31))
                                                     : int'($urandom_range(0, 12));
                rm[i] = int'($urandom_range(0, 1023));
                tp[i] = int'($urandom_range(1, 255));
                rl[i] = ($urandom_range(0, 3) == 0) ? 1 : 0;
            end
            step("R2");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule